// File: doc/BRIEF.md
# Tagged Index Effective Address Unit

This unit turns a 36-bit instruction word into a 15-bit operand address. It keeps a bank of seven 15-bit index registers. It subtracts the indexed contribution chosen by the word's 3-bit tag from the word's 15-bit address field, and the subtraction wraps modulo 2^15. Words of the index-control class bypass indexing and deliver the address field unchanged. They also write the word's 15-bit decrement field into the registers that the tag selects.

The unit leaves reset in a compatibility mode. In that mode only three registers, A, B and C, take part. Each tag bit picks one of them, and the picked values are ORed together before the subtraction. A leave command switches the unit to an extended mode, where a non-zero tag value from 1 to 7 names exactly one of seven registers. An enter command switches it back. A word whose two flag bits are both 1 is indirect. The unit reads memory at the computed address and then forms the final address from the tag and address field of the fetched word, with one level only.

Top module: `tagged_ea_unit`

## Requirements
- R1: After synchronous active-low reset, ea_valid and mem_rd_req are 0, the unit is in compatibility mode and all seven index registers hold 0, so any direct indexed request returns its address field unchanged.
- R2: Fields, using the leftmost-numbered convention (SV bit = 35 - n): address field Y = req_word[14:0], tag = req_word[17:15], flag = req_word[23:22], decrement = req_word[32:18]. A direct request accepted at a clock edge raises ea_valid for exactly the following cycle, with ea_out holding the result.
- R3: The result is Y minus the index contribution, taken modulo 2^15, and no overflow is reported.
- R4: In compatibility mode, tag bit req_word[15] selects A (register 1), req_word[16] selects B (register 2) and req_word[17] selects C (register 4). The contribution is the bitwise OR of all selected registers, and a tag of 0 contributes 0.
- R5: In compatibility mode, an index-control load whose tag has several bits set writes the decrement into every selected register.
- R6: For an index-control request (req_xctl=1), ea_out is Y, with no indexing and no indirection even when the flag bits are 11, and no memory read is issued. A tag of 0 writes no register.
- R7: mode_leave switches to extended mode. There, tag value t (1..7) selects register t alone, for both indexing and loading. mode_enter returns the unit to compatibility mode, and mode_leave has priority when both are high. Register contents persist across mode changes.
- R8: A mode command in the same cycle as a request takes effect from the next cycle. The request in that cycle uses the old mode.
- R9: A non-control request with flag bits 11 raises mem_rd_req with mem_rd_addr = Y - C(T). The request stays high with a stable address until mem_rd_valid is seen. The cycle after that response, ea_valid is 1 and ea_out is Y' - C(T') from the fetched word's tag and address field, under the current mode. The fetched word's flag is ignored.
- R10: While a memory read is pending, new requests, including index loads, are ignored and ea_valid stays 0. A mem_rd_valid with no read pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Instruction word presented for address formation |
| req_word | input | 36 | Instruction word |
| req_xctl | input | 1 | Word is of the index-control class (load decrement, no indexing) |
| mode_leave | input | 1 | Switch to seven-register mode |
| mode_enter | input | 1 | Switch back to compatibility (OR-combining) mode |
| mem_rd_req | output | 1 | Indirect-word read request, held until answered |
| mem_rd_addr | output | 15 | Address of the indirect word |
| mem_rd_valid | input | 1 | Read data is valid this cycle |
| mem_rd_data | input | 36 | Fetched indirect word |
| ea_valid | output | 1 | One-cycle strobe: ea_out holds a finished address |
| ea_out | output | 15 | Effective address |

## Verification
Two events can coincide in one cycle: a mode command and an address request. A request in the same cycle is provoked with mode_leave and again with mode_enter, using tag 3. Tag 3 gives different contributions in the two modes, A|B in compatibility mode and register 3 in extended mode. The result must show the old mode, and the next request must show the new one. The same reasoning covers an index load followed at once by an indexed access, and a request or stray load arriving while an indirect read is pending. The bench judges the latter afterwards by reading the untouched register through a normal indexed request.

// File: rtl/ea_pkg.sv
// Package: shared widths, field positions and state type for the
// effective-address unit. Assumes the 36-bit word is numbered from the
// left, so field bit n maps to SystemVerilog bit (WORD_W-1-n).
package ea_pkg;
    localparam int WORD_W   = 36;
    localparam int ADDR_W   = 15;
    localparam int TAG_W    = 3;
    localparam int FLAG_W   = 2;
    localparam int NUM_XR   = (1 << TAG_W) - 1;
    localparam int Y_LSB    = 0;
    localparam int TAG_LSB  = Y_LSB + ADDR_W;
    localparam int DEC_LSB  = TAG_LSB + TAG_W;
    localparam int FLAG_LSB = WORD_W - 14;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } ea_state_e;
endpackage

// File: rtl/ea_xreg_bank.sv
// Index register bank: NUM_XR registers numbered 1..NUM_XR, each written
// from a shared data bus when its mask bit is set. Assumes the mask is
// already qualified by the controller; several bits may be set at once.
module ea_xreg_bank #(
    parameter int ADDR_W = ea_pkg::ADDR_W,
    parameter int NUM_XR = ea_pkg::NUM_XR
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_XR:1]                wr_mask,
    input  logic [ADDR_W-1:0]              wr_data,
    output logic [NUM_XR:1][ADDR_W-1:0]    xr_q
);
    for (genvar r = 1; r <= NUM_XR; r++) begin : g_reg
        // Hold register r; load the shared data when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                xr_q[r] <= '0;
            else if (wr_mask[r])
                xr_q[r] <= wr_data;
        end

        // R5/R7: a selected register carries the written value next cycle.
        a_r5_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
            wr_mask[r] |=> (xr_q[r] == $past(wr_data)));

        // R10: an unselected register keeps its value.
        a_r10_reg_kept: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_mask[r] |=> $stable(xr_q[r]));
    end
endmodule

// File: rtl/ea_idx_select.sv
// Index selection: turns a tag and the mode into a register select mask
// and the combined contribution. Compatibility mode lets tag bit i pick
// register 2^i and ORs the picked values; extended mode picks register
// number equal to the tag. Assumes tag 0 selects nothing in both modes.
module ea_idx_select #(
    parameter int ADDR_W = ea_pkg::ADDR_W,
    parameter int TAG_W  = ea_pkg::TAG_W,
    parameter int NUM_XR = ea_pkg::NUM_XR
) (
    input  logic                           ext_mode,
    input  logic [TAG_W-1:0]               tag,
    input  logic [NUM_XR:1][ADDR_W-1:0]    xr_q,
    output logic [NUM_XR:1]                sel_mask,
    output logic [ADDR_W-1:0]              contrib
);
    for (genvar r = 1; r <= NUM_XR; r++) begin : g_sel
        logic compat_hit;
        if ((r & (r - 1)) == 0) begin : g_pow2
            assign compat_hit = tag[$clog2(r)];
        end else begin : g_other
            assign compat_hit = 1'b0;
        end
        assign sel_mask[r] = ext_mode ? (tag == TAG_W'(r)) : compat_hit;
    end

    // OR together every selected register value.
    always_comb begin
        contrib = '0;
        for (int r = 1; r <= NUM_XR; r++) begin
            if (sel_mask[r])
                contrib = contrib | xr_q[r];
        end
    end
endmodule

// File: rtl/ea_ctrl.sv
// Controller: accepts requests while idle, holds the mode bit, issues and
// holds the indirect read, and registers the finished address with a
// one-cycle strobe. Assumes calc_ea is the indexed result for the word
// currently in use (request word when idle, fetched word when fetching).
module ea_ctrl #(
    parameter int ADDR_W = ea_pkg::ADDR_W,
    parameter int FLAG_W = ea_pkg::FLAG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_xctl,
    input  logic [FLAG_W-1:0]  req_flag,
    input  logic [ADDR_W-1:0]  req_y,
    input  logic               mode_leave,
    input  logic               mode_enter,
    input  logic               mem_rd_valid,
    input  logic [ADDR_W-1:0]  calc_ea,
    output logic               ext_mode,
    output logic               fetching,
    output logic               load_en,
    output logic               mem_rd_req,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    output logic               ea_valid,
    output logic [ADDR_W-1:0]  ea_out
);
    import ea_pkg::*;

    ea_state_e state;
    logic      accept;
    logic      go_indirect;

    assign accept      = (state == ST_IDLE) && req_valid;
    assign go_indirect = accept && !req_xctl && (req_flag == {FLAG_W{1'b1}});
    assign load_en     = accept && req_xctl;
    assign fetching    = (state == ST_FETCH);

    // Track the register-count mode; leave wins over enter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ext_mode <= 1'b0;
        else if (mode_leave)
            ext_mode <= 1'b1;
        else if (mode_enter)
            ext_mode <= 1'b0;
    end

    // Sequence direct and indirect address formation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            ea_valid    <= 1'b0;
            ea_out      <= '0;
            mem_rd_req  <= 1'b0;
            mem_rd_addr <= '0;
        end else begin
            ea_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (go_indirect) begin
                        state       <= ST_FETCH;
                        mem_rd_req  <= 1'b1;
                        mem_rd_addr <= calc_ea;
                    end else if (accept) begin
                        ea_valid <= 1'b1;
                        ea_out   <= req_xctl ? req_y : calc_ea;
                    end
                end
                ST_FETCH: begin
                    if (mem_rd_valid) begin
                        state      <= ST_IDLE;
                        mem_rd_req <= 1'b0;
                        ea_valid   <= 1'b1;
                        ea_out     <= calc_ea;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: reset leaves the outputs quiet.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!ea_valid && !mem_rd_req));

    // R2: a direct request yields a strobe on the next cycle.
    a_r2_direct_next: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !go_indirect) |=> ea_valid);

    // R6: an index-control request returns its address field untouched.
    a_r6_ctl_plain_y: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_xctl) |=> (ea_valid && !mem_rd_req && ea_out == $past(req_y)));

    // R7: the leave command always lands in extended mode.
    a_r7_leave_lands: assert property (@(posedge clk) disable iff (!rst_n)
        mode_leave |=> ext_mode);

    // R7: enter without leave returns to compatibility mode.
    a_r7_enter_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_enter && !mode_leave) |=> !ext_mode);

    // R9: an unanswered read stays asserted with a steady address.
    a_r9_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R9: an answered read completes on the next cycle.
    a_r9_read_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_valid) |=> (ea_valid && !mem_rd_req));

    // R10: no strobe while a read is outstanding.
    a_r10_silent_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !ea_valid);
endmodule

// File: rtl/tagged_ea_unit.sv
// Top: forms a 15-bit effective address from a 36-bit word. Chooses the
// request word or the fetched indirect word as operand source, selects
// index registers by tag and mode, subtracts modulo 2^ADDR_W and hands
// the result to the controller. Assumes the word layout in ea_pkg.
module tagged_ea_unit #(
    parameter int WORD_W = ea_pkg::WORD_W,
    parameter int ADDR_W = ea_pkg::ADDR_W,
    parameter int TAG_W  = ea_pkg::TAG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [WORD_W-1:0]  req_word,
    input  logic               req_xctl,
    input  logic               mode_leave,
    input  logic               mode_enter,
    output logic               mem_rd_req,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [WORD_W-1:0]  mem_rd_data,
    output logic               ea_valid,
    output logic [ADDR_W-1:0]  ea_out
);
    localparam int NUM_XR   = (1 << TAG_W) - 1;
    localparam int FLAG_W   = ea_pkg::FLAG_W;
    localparam int TAG_LSB  = ADDR_W;
    localparam int DEC_LSB  = TAG_LSB + TAG_W;
    localparam int FLAG_LSB = WORD_W - 14;

    logic                         ext_mode;
    logic                         fetching;
    logic                         load_en;
    logic [WORD_W-1:0]            src_word;
    logic [TAG_W-1:0]             src_tag;
    logic [ADDR_W-1:0]            src_y;
    logic [NUM_XR:1]              sel_mask;
    logic [NUM_XR:1]              wr_mask;
    logic [ADDR_W-1:0]            contrib;
    logic [ADDR_W-1:0]            calc_ea;
    logic [NUM_XR:1][ADDR_W-1:0]  xr_q;

    // Operand source: the fetched word during an indirect read.
    assign src_word = fetching ? mem_rd_data : req_word;
    assign src_tag  = src_word[TAG_LSB +: TAG_W];
    assign src_y    = src_word[ADDR_W-1:0];
    assign calc_ea  = src_y - contrib;
    assign wr_mask  = load_en ? sel_mask : '0;

    ea_idx_select #(
        .ADDR_W (ADDR_W),
        .TAG_W  (TAG_W),
        .NUM_XR (NUM_XR)
    ) i_select (
        .ext_mode (ext_mode),
        .tag      (src_tag),
        .xr_q     (xr_q),
        .sel_mask (sel_mask),
        .contrib  (contrib)
    );

    ea_xreg_bank #(
        .ADDR_W (ADDR_W),
        .NUM_XR (NUM_XR)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_data (req_word[DEC_LSB +: ADDR_W]),
        .xr_q    (xr_q)
    );

    ea_ctrl #(
        .ADDR_W (ADDR_W),
        .FLAG_W (FLAG_W)
    ) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_xctl     (req_xctl),
        .req_flag     (req_word[FLAG_LSB +: FLAG_W]),
        .req_y        (req_word[ADDR_W-1:0]),
        .mode_leave   (mode_leave),
        .mode_enter   (mode_enter),
        .mem_rd_valid (mem_rd_valid),
        .calc_ea      (calc_ea),
        .ext_mode     (ext_mode),
        .fetching     (fetching),
        .load_en      (load_en),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .ea_valid     (ea_valid),
        .ea_out       (ea_out)
    );

    // R3: the strobed address never depends on anything but wrapped width.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fetching && !req_xctl && contrib == '0
         && req_word[FLAG_LSB +: FLAG_W] != {FLAG_W{1'b1}})
        |=> (ea_out == $past(req_word[ADDR_W-1:0])));
endmodule

// File: tb/test_tagged_ea_unit.sv
// Directed bench: one task per scenario, each checking its own results.
module test_tagged_ea_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [35:0] req_word = '0;
    logic        req_xctl = 1'b0;
    logic        mode_leave = 1'b0;
    logic        mode_enter = 1'b0;
    logic        mem_rd_req;
    logic [14:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [35:0] mem_rd_data = '0;
    logic        ea_valid;
    logic [14:0] ea_out;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    logic [14:0] xr_m [1:7];
    logic        m_ext = 1'b0;

    tagged_ea_unit i_tagged_ea_unit (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_word (req_word),
        .req_xctl (req_xctl), .mode_leave (mode_leave), .mode_enter (mode_enter),
        .mem_rd_req (mem_rd_req), .mem_rd_addr (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
        .ea_valid (ea_valid), .ea_out (ea_out)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 20000)", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] mkg(input logic [1:0] flag, input logic [2:0] tag, input logic [14:0] y);
        return {12'b0, flag, 4'b0, tag, y};
    endfunction

    function automatic logic [35:0] mkx(input logic [14:0] dec, input logic [2:0] tag, input logic [14:0] y);
        return {3'b0, dec, tag, y};
    endfunction

    function automatic logic picks(input int r, input logic [2:0] tag);
        if (m_ext) return (tag == 3'(r));
        return (r == 1 && tag[0]) || (r == 2 && tag[1]) || (r == 4 && tag[2]);
    endfunction

    function automatic logic [14:0] model_ea(input logic [2:0] tag, input logic [14:0] y);
        logic [14:0] c = '0;
        for (int r = 1; r <= 7; r++) if (picks(r, tag)) c = c | xr_m[r];
        return y - c;
    endfunction

    // Present one request for one cycle, optionally with mode commands.
    task automatic send(input logic [35:0] w, input logic xc, input logic lv, input logic en);
        @(negedge clk);
        req_valid = 1'b1; req_word = w; req_xctl = xc; mode_leave = lv; mode_enter = en;
        @(negedge clk);
        req_valid = 1'b0; req_xctl = 1'b0; mode_leave = 1'b0; mode_enter = 1'b0;
    endtask

    // Direct request: strobe one cycle later with the expected address.
    task automatic direct(input string req, input logic [35:0] w, input logic [14:0] exp);
        send(w, 1'b0, 1'b0, 1'b0);
        check({req, " strobe"}, {35'b0, ea_valid}, 36'd1);
        check({req, " address"}, {21'b0, ea_out}, {21'b0, exp});
        check({req, " no read"}, {35'b0, mem_rd_req}, 36'd0);
    endtask

    // Index-control load: returns Y, writes selected registers in the model.
    task automatic xload(input string req, input logic [14:0] dec, input logic [2:0] tag, input logic [14:0] y);
        send(mkx(dec, tag, y), 1'b1, 1'b0, 1'b0);
        check({req, " ctl strobe"}, {35'b0, ea_valid}, 36'd1);
        check({req, " ctl address"}, {21'b0, ea_out}, {21'b0, y});
        check({req, " ctl no read"}, {35'b0, mem_rd_req}, 36'd0);
        for (int r = 1; r <= 7; r++) if (picks(r, tag)) xr_m[r] = dec;
    endtask

    task automatic t_reset_state();
        check("R1 ea_valid after reset", {35'b0, ea_valid}, 36'd0);
        check("R1 mem_rd_req after reset", {35'b0, mem_rd_req}, 36'd0);
        direct("R1 cleared registers", mkg(2'b00, 3'b111, 15'h1234), 15'h1234);
        @(negedge clk);
        check("R2 strobe lasts one cycle", {35'b0, ea_valid}, 36'd0);
    endtask

    task automatic t_compat_or();
        xload("R6 load A", 15'h0010, 3'b001, 15'h0ABC);
        xload("R5 load B and C together", 15'h0103, 3'b110, 15'h0001);
        direct("R4 tag A", mkg(2'b00, 3'b001, 15'h1000), 15'h0FF0);
        direct("R5 tag B written", mkg(2'b00, 3'b010, 15'h1000), 15'h0EFD);
        direct("R5 tag C written", mkg(2'b00, 3'b100, 15'h1000), 15'h0EFD);
        direct("R4 tag A|B ORed", mkg(2'b00, 3'b011, 15'h1000), 15'h0EED);
        direct("R4 tag A|B|C ORed", mkg(2'b00, 3'b111, 15'h1000), 15'h0EED);
        direct("R4 tag zero", mkg(2'b00, 3'b000, 15'h1000), 15'h1000);
    endtask

    task automatic t_wrap();
        direct("R3 wrap below zero", mkg(2'b00, 3'b001, 15'h0005), 15'h7FF5);
        direct("R3 wrap zero minus", mkg(2'b10, 3'b011, 15'h0000), model_ea(3'b011, 15'h0000));
    endtask

    task automatic t_ctl_no_index();
        // Decrement 0x0030 puts 11 in the flag bits [23:22]; tag 0 writes nothing.
        xload("R6 flag bits ignored", 15'h0030, 3'b000, 15'h0044);
        direct("R6 tag zero left A", mkg(2'b00, 3'b001, 15'h0100), 15'h00F0);
    endtask

    task automatic t_ext_mode();
        send(mkg(2'b00, 3'b000, 15'h0000), 1'b0, 1'b1, 1'b0);
        m_ext = 1'b1;
        xload("R7 load reg3", 15'h0200, 3'd3, 15'h0003);
        xload("R7 load reg5", 15'h0400, 3'd5, 15'h0005);
        direct("R7 tag3 single", mkg(2'b00, 3'd3, 15'h1000), 15'h0E00);
        direct("R7 tag5 single", mkg(2'b00, 3'd5, 15'h1000), 15'h0C00);
        direct("R7 tag7 no OR", mkg(2'b00, 3'd7, 15'h1000), 15'h1000);
        direct("R7 tag2 is B", mkg(2'b00, 3'd2, 15'h1000), 15'h0EFD);
        send(mkg(2'b00, 3'b000, 15'h0000), 1'b0, 1'b0, 1'b1);
        m_ext = 1'b0;
        direct("R7 back to OR mode", mkg(2'b00, 3'd3, 15'h1000), 15'h0EED);
    endtask

    task automatic t_mode_same_cycle();
        send(mkg(2'b00, 3'd3, 15'h1000), 1'b0, 1'b1, 1'b0);
        check("R8 leave with request uses old mode", {21'b0, ea_out}, {21'b0, 15'h0EED});
        m_ext = 1'b1;
        direct("R8 leave effective next", mkg(2'b00, 3'd3, 15'h1000), 15'h0E00);
        send(mkg(2'b00, 3'd3, 15'h1000), 1'b0, 1'b0, 1'b1);
        check("R8 enter with request uses old mode", {21'b0, ea_out}, {21'b0, 15'h0E00});
        m_ext = 1'b0;
        direct("R8 enter effective next", mkg(2'b00, 3'd3, 15'h1000), 15'h0EED);
    endtask

    // Indirect access with a given response delay; optional intrusions.
    task automatic indirect(input string req, input logic [35:0] w, input logic [35:0] fw,
                            input int delay, input logic intrude);
        logic [14:0] exp_addr = model_ea(w[17:15], w[14:0]);
        send(w, 1'b0, 1'b0, 1'b0);
        check({req, " read raised"}, {35'b0, mem_rd_req}, 36'd1);
        check({req, " read address"}, {21'b0, mem_rd_addr}, {21'b0, exp_addr});
        check({req, " no early strobe"}, {35'b0, ea_valid}, 36'd0);
        for (int k = 0; k < delay; k++) begin
            if (intrude) begin
                req_valid = 1'b1; req_xctl = 1'b1; req_word = mkx(15'h7777, 3'b011, 15'h0222);
            end
            @(negedge clk);
            req_valid = 1'b0; req_xctl = 1'b0;
            check({req, " R10 quiet while pending"}, {35'b0, ea_valid}, 36'd0);
            check({req, " R9 read held"}, {20'b0, mem_rd_req, mem_rd_addr}, {20'b0, 1'b1, exp_addr});
        end
        mem_rd_valid = 1'b1; mem_rd_data = fw;
        @(negedge clk);
        mem_rd_valid = 1'b0; mem_rd_data = '0;
        check({req, " final strobe"}, {35'b0, ea_valid}, 36'd1);
        check({req, " final address"}, {21'b0, ea_out}, {21'b0, model_ea(fw[17:15], fw[14:0])});
        check({req, " read dropped"}, {35'b0, mem_rd_req}, 36'd0);
        @(negedge clk);
        check({req, " one level only"}, {35'b0, mem_rd_req}, 36'd0);
    endtask

    task automatic t_indirect();
        indirect("R9 delayed", mkg(2'b11, 3'b001, 15'h0100), mkg(2'b11, 3'b010, 15'h2000), 3, 1'b0);
        indirect("R9 same-cycle reply", mkg(2'b11, 3'b000, 15'h0055), mkg(2'b00, 3'b011, 15'h0300), 0, 1'b0);
        send(mkg(2'b00, 3'b000, 15'h0000), 1'b0, 1'b1, 1'b0);
        m_ext = 1'b1;
        indirect("R9 extended fetched tag", mkg(2'b11, 3'd3, 15'h0400), mkg(2'b01, 3'd5, 15'h0500), 1, 1'b0);
        send(mkg(2'b00, 3'b000, 15'h0000), 1'b0, 1'b0, 1'b1);
        m_ext = 1'b0;
    endtask

    task automatic t_busy_ignore();
        indirect("R10 intrusions", mkg(2'b11, 3'b001, 15'h0200), mkg(2'b00, 3'b001, 15'h0300), 2, 1'b0);
        indirect("R10 load during read", mkg(2'b11, 3'b000, 15'h0010), mkg(2'b00, 3'b000, 15'h0020), 2, 1'b1);
        direct("R10 A untouched", mkg(2'b00, 3'b001, 15'h1000), 15'h0FF0);
        direct("R10 B untouched", mkg(2'b00, 3'b010, 15'h1000), 15'h0EFD);
        @(negedge clk);
        mem_rd_valid = 1'b1; mem_rd_data = mkg(2'b00, 3'b000, 15'h0777);
        @(negedge clk);
        mem_rd_valid = 1'b0;
        check("R10 stray response no strobe", {35'b0, ea_valid}, 36'd0);
        check("R10 stray response keeps address", {21'b0, ea_out}, {21'b0, 15'h0EFD});
    endtask

    initial begin
        for (int r = 1; r <= 7; r++) xr_m[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_compat_or();
        t_wrap();
        t_ctl_no_index();
        t_ext_mode();
        t_mode_same_cycle();
        t_indirect();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule